// File: doc/BRIEF.md
# DTMF Transceiver Register Interface

This block is the processor-facing register file of a DTMF transceiver. A host reaches it through a chip select, a read/write strobe, one register-select line and separate 8-bit write and read data buses. Every clock cycle with the chip select high counts as one access.

The register-select line picks between two banks:
- **Select = 0 (data bank).** A write loads the transmit code that chooses the tone pair to send. A read returns the code of the last validly decoded digit.
- **Select = 1 (control/status bank).** A write goes to one of two control registers that share this address. A read returns the status flags.

The first control register (A) can redirect exactly one following write to the second control register (B). After that write, the shared address falls back to A.

The tone decoder and the tone transmitter are outside the block. They appear as ports: a one-cycle "digit valid" pulse with a 4-bit code, and a one-cycle "ready for data" pulse. The block produces an interrupt as an active-low level with its own output enable, which models an open-drain pin. A system reset after power-up puts the control and status state into a known condition.

Top module: `dtmf_regif`

## Requirements
- R1: After reset, `tone_en`, `burst_mode` and `irq_oe` are 0 and `irq_n` is 1. A status read returns 0x02, and the next control write lands in control A.
- R2: A `dec_valid` pulse stores `dec_code` as the receive code and sets the receive-ready flag (status bit 2).
- R3: A read with select 0 returns the receive code in bits 3:0, with bits 7:4 zero, on `rdata` in the following cycle. It also clears receive-ready.
- R4: Control writes (select 1) go to A unless a redirect is pending.
  - A write to A with bit 3 set makes the very next control write go to B.
  - The control write after that one goes to A again.
- R5: A write with select 0 drives `wdata[3:0]` onto `tx_code` from the next cycle and clears transmit-empty (status bit 1). A `tx_ready` pulse sets transmit-empty.
- R6: A read with select 1 returns `{5'b0, receive-ready, transmit-empty, irq-pending}` on `rdata` in the following cycle. It also clears irq-pending (status bit 0).
- R7: While control A bit 2 (interrupt enable) is set, a `dec_valid` pulse sets irq-pending. From the next cycle `irq_n` is 0 and `irq_oe` is 1.
- R8: A `tx_ready` pulse sets irq-pending only when interrupt enable is set and control B bit 0 (burst mode, driven on `burst_mode`) is set.
- R9: With interrupt enable clear, neither event sets irq-pending.
- R10: When an event that sets a flag arrives in the same cycle as an access that clears that flag, the flag ends up set.
- R11: Cycles with `csel` low change no register and leave `rdata` unchanged.
- R12: `tone_en` follows control A bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| csel | input | 1 | Chip select; high means an access this cycle |
| rw | input | 1 | 1 = read, 0 = write |
| rsel | input | 1 | 0 = data bank, 1 = control/status bank |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, registered |
| dec_valid | input | 1 | One-cycle pulse: decoder has a valid digit |
| dec_code | input | 4 | Code of the decoded digit |
| tx_ready | input | 1 | One-cycle pulse: transmitter can take more data |
| tx_code | output | 4 | Code of the tone pair to transmit |
| tone_en | output | 1 | Tone output enable (control A bit 0) |
| burst_mode | output | 1 | Burst mode (control B bit 0) |
| irq_n | output | 1 | Interrupt request, active low |
| irq_oe | output | 1 | Drive enable of the interrupt line |

## Verification
The bench builds the block with its default `DATA_W` of 8. This makes the zero padding above the 4-bit code and above the 3 status flags visible on `rdata`. It sweeps all 16 decoder codes through the receive path. It exercises both settings of the redirect flag, so control A and control B are each written while the other must stay unchanged. It also drives events into the same cycles as the accesses that clear their flags, which exercises the set-wins ordering.

// File: rtl/dtmf_regif_pkg.sv
package dtmf_regif_pkg;
    localparam int CODE_W    = 4;
    localparam int CR_W      = 4;
    localparam int ST_W      = 3;
    localparam int CRA_TOE   = 0;
    localparam int CRA_IE    = 2;
    localparam int CRA_REDIR = 3;
    localparam int CRB_BURST = 0;
    localparam int ST_IRQ    = 0;
    localparam int ST_TXE    = 1;
    localparam int ST_RXR    = 2;

    typedef struct packed {
        logic [CR_W-1:0] cra;
        logic [CR_W-1:0] crb;
        logic            to_b;
    } ctl_t;

    typedef struct packed {
        logic irq_pend;
        logic tx_empty;
        logic rx_ready;
    } flags_t;
endpackage

// File: rtl/dtmf_ctl_bank.sv
module dtmf_ctl_bank
    import dtmf_regif_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [CR_W-1:0] wr_val,
    output logic [CR_W-1:0] cra,
    output logic [CR_W-1:0] crb,
    output logic            to_b
);
    ctl_t ctl_d, ctl_q;

    always_comb begin
        ctl_d = ctl_q;
        if (wr_en) begin
            if (ctl_q.to_b) begin
                ctl_d.crb  = wr_val;
                ctl_d.to_b = 1'b0;
            end else begin
                ctl_d.cra  = wr_val;
                ctl_d.to_b = wr_val[CRA_REDIR];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    assign cra  = ctl_q.cra;
    assign crb  = ctl_q.crb;
    assign to_b = ctl_q.to_b;

    AST_REDIRECT_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && to_b) |=> !to_b) else $error("redirect held"); // R4
    AST_B_ONLY_REDIRECTED: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !to_b) |=> $stable(crb)) else $error("B written"); // R4
endmodule

// File: rtl/dtmf_stat_flags.sv
module dtmf_stat_flags
    import dtmf_regif_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic rx_set,
    input  logic rx_clr,
    input  logic tx_set,
    input  logic tx_clr,
    input  logic irq_clr,
    input  logic irq_en,
    input  logic burst,
    output logic irq_pend,
    output logic tx_empty,
    output logic rx_ready
);
    flags_t fl_d, fl_q;

    always_comb begin
        fl_d = fl_q;
        if (rx_clr)  fl_d.rx_ready = 1'b0;
        if (tx_clr)  fl_d.tx_empty = 1'b0;
        if (irq_clr) fl_d.irq_pend = 1'b0;
        if (rx_set) begin
            fl_d.rx_ready = 1'b1;
            if (irq_en) fl_d.irq_pend = 1'b1;
        end
        if (tx_set) begin
            fl_d.tx_empty = 1'b1;
            if (irq_en && burst) fl_d.irq_pend = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) fl_q <= '{irq_pend: 1'b0, tx_empty: 1'b1, rx_ready: 1'b0};
        else        fl_q <= fl_d;
    end

    assign irq_pend = fl_q.irq_pend;
    assign tx_empty = fl_q.tx_empty;
    assign rx_ready = fl_q.rx_ready;

    AST_RX_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        rx_set |=> rx_ready) else $error("rx flag lost"); // R10
    AST_TX_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_clr && !tx_set) |=> !tx_empty) else $error("tx flag kept"); // R5
    AST_IRQ_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_clr && !rx_set && !tx_set) |=> !irq_pend) else $error("irq kept"); // R6
    AST_NO_IRQ_WITHOUT_BURST: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_set && !burst && !rx_set && !irq_pend) |=> !irq_pend) else $error("irq in non-burst"); // R8
    AST_NO_IRQ_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq_en && !irq_pend) |=> !irq_pend) else $error("irq while disabled"); // R9
endmodule

// File: rtl/dtmf_regif.sv
module dtmf_regif
    import dtmf_regif_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              csel,
    input  logic              rw,
    input  logic              rsel,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic              dec_valid,
    input  logic [CODE_W-1:0] dec_code,
    input  logic              tx_ready,
    output logic [CODE_W-1:0] tx_code,
    output logic              tone_en,
    output logic              burst_mode,
    output logic              irq_n,
    output logic              irq_oe
);
    localparam int PAD_CODE = DATA_W - CODE_W;
    localparam int PAD_ST   = DATA_W - ST_W;

    typedef struct packed {
        logic [CODE_W-1:0] rx_code;
        logic [CODE_W-1:0] tx_code;
        logic [DATA_W-1:0] rdata;
    } dat_t;

    dat_t dat_d, dat_q;

    logic            rd_dat, wr_dat, rd_st, wr_ctl;
    logic [CR_W-1:0] cra, crb;
    logic            to_b;
    logic            irq_pend, tx_empty, rx_ready;
    logic [ST_W-1:0] status;

    assign rd_dat = csel &&  rw && !rsel;
    assign wr_dat = csel && !rw && !rsel;
    assign rd_st  = csel &&  rw &&  rsel;
    assign wr_ctl = csel && !rw &&  rsel;

    dtmf_ctl_bank u_ctl (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_ctl),
        .wr_val (wdata[CR_W-1:0]),
        .cra    (cra),
        .crb    (crb),
        .to_b   (to_b)
    );

    dtmf_stat_flags u_flags (
        .clk      (clk),
        .rst_n    (rst_n),
        .rx_set   (dec_valid),
        .rx_clr   (rd_dat),
        .tx_set   (tx_ready),
        .tx_clr   (wr_dat),
        .irq_clr  (rd_st),
        .irq_en   (cra[CRA_IE]),
        .burst    (crb[CRB_BURST]),
        .irq_pend (irq_pend),
        .tx_empty (tx_empty),
        .rx_ready (rx_ready)
    );

    always_comb begin
        status         = '0;
        status[ST_IRQ] = irq_pend;
        status[ST_TXE] = tx_empty;
        status[ST_RXR] = rx_ready;
    end

    always_comb begin
        dat_d = dat_q;
        if (rd_dat) dat_d.rdata   = {{PAD_CODE{1'b0}}, dat_q.rx_code};
        if (rd_st)  dat_d.rdata   = {{PAD_ST{1'b0}}, status};
        if (wr_dat) dat_d.tx_code = wdata[CODE_W-1:0];
        if (dec_valid) dat_d.rx_code = dec_code;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) dat_q <= '0;
        else        dat_q <= dat_d;
    end

    assign rdata      = dat_q.rdata;
    assign tx_code    = dat_q.tx_code;
    assign tone_en    = cra[CRA_TOE];
    assign burst_mode = crb[CRB_BURST];
    assign irq_n      = !irq_pend;
    assign irq_oe     = irq_pend;

    AST_RX_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        dec_valid |=> (dat_q.rx_code == $past(dec_code))) else $error("code lost"); // R2
    AST_IDLE_RDATA: assert property (@(posedge clk) disable iff (!rst_n)
        !csel |=> $stable(rdata)) else $error("rdata moved"); // R11
    AST_IDLE_TX: assert property (@(posedge clk) disable iff (!rst_n)
        !csel |=> $stable(tx_code)) else $error("tx_code moved"); // R11
    AST_IRQ_ON_DIGIT: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && cra[CRA_IE]) |=> (!irq_n && irq_oe)) else $error("no irq"); // R7
endmodule

// File: tb/dtmf_regif_tb.sv
module dtmf_regif_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       csel = 0, rw = 0, rsel = 0, dec_valid = 0, tx_ready = 0;
    logic [7:0] wdata = 0;
    logic [3:0] dec_code = 0;
    logic [7:0] rdata;
    logic [3:0] tx_code;
    logic       tone_en, burst_mode, irq_n, irq_oe;

    int checks = 0, fails = 0;

    always #2.5 clk = ~clk;

    dtmf_regif u_dut (
        .clk(clk), .rst_n(rst_n), .csel(csel), .rw(rw), .rsel(rsel),
        .wdata(wdata), .rdata(rdata), .dec_valid(dec_valid), .dec_code(dec_code),
        .tx_ready(tx_ready), .tx_code(tx_code), .tone_en(tone_en),
        .burst_mode(burst_mode), .irq_n(irq_n), .irq_oe(irq_oe)
    );

    // behavioural reference
    int m_cra, m_crb, m_tob, m_rx, m_tx, m_rd, m_ip, m_txe, m_rxr;
    always @(posedge clk) begin
        int ie, bm;
        if (!rst_n) begin
            m_cra = 0; m_crb = 0; m_tob = 0; m_rx = 0; m_tx = 0; m_rd = 0;
            m_ip = 0; m_txe = 1; m_rxr = 0;
        end else begin
            ie = (m_cra >> 2) & 1;
            bm = m_crb & 1;
            if (csel && rw) begin
                if (!rsel) begin m_rd = m_rx; m_rxr = 0; end
                else begin m_rd = m_rxr * 4 + m_txe * 2 + m_ip; m_ip = 0; end
            end
            if (csel && !rw && !rsel) begin m_tx = wdata & 15; m_txe = 0; end
            if (csel && !rw && rsel) begin
                if (m_tob != 0) begin m_crb = wdata & 15; m_tob = 0; end
                else begin m_cra = wdata & 15; m_tob = (wdata >> 3) & 1; end
            end
            if (dec_valid) begin m_rx = dec_code; m_rxr = 1; if (ie != 0) m_ip = 1; end
            if (tx_ready) begin m_txe = 1; if (ie != 0 && bm != 0) m_ip = 1; end
        end
    end

    task automatic chk(input string tag, input int got, input int exp);
        checks++;
        if (got != exp) begin
            fails++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
        end
    endtask

    // cycle-by-cycle comparison against the model
    always @(negedge clk) if (rst_n) begin
        chk("R3/R6 rdata", rdata, m_rd);
        chk("R5 tx_code", tx_code, m_tx);
        chk("R12 tone_en", tone_en, m_cra & 1);
        chk("R4/R8 burst_mode", burst_mode, m_crb & 1);
        chk("R7 irq_n", irq_n, m_ip == 0);
        chk("R7 irq_oe", irq_oe, m_ip);
    end

    task automatic drv(input logic c, input logic r, input logic s, input int wd,
                       input logic dv, input int dc, input logic tr);
        @(negedge clk);
        csel = c; rw = r; rsel = s; wdata = wd[7:0];
        dec_valid = dv; dec_code = dc[3:0]; tx_ready = tr;
    endtask
    task automatic idle(); drv(0, 0, 0, 0, 0, 0, 0); endtask
    task automatic wr(input logic s, input int v); drv(1, 0, s, v, 0, 0, 0); idle(); endtask
    task automatic rd(input logic s); drv(1, 1, s, 0, 0, 0, 0); idle(); endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        idle();
        chk("R1 tone_en", tone_en, 0);
        chk("R1 burst_mode", burst_mode, 0);
        chk("R1 irq_n", irq_n, 1);
        chk("R1 irq_oe", irq_oe, 0);
        rd(1);
        chk("R1 status", rdata, 8'h02);
        // A: redirect+IE+tone, then B: burst
        wr(1, 8'h0D);
        chk("R12 tone_en", tone_en, 1);
        chk("R1 first write to A", burst_mode, 0);
        wr(1, 8'h01);
        chk("R4 B written", burst_mode, 1);
        wr(1, 8'h04);
        chk("R4 back to A", tone_en, 0);
        chk("R4 B kept", burst_mode, 1);
        // digit receive with interrupt
        drv(0, 0, 0, 0, 1, 11, 0); idle();
        chk("R7 irq_n", irq_n, 0);
        chk("R7 irq_oe", irq_oe, 1);
        rd(1);
        chk("R2 status", rdata, 8'h07);
        chk("R6 irq cleared", irq_n, 1);
        rd(0);
        chk("R3 rx code", rdata, 8'h0B);
        rd(1);
        chk("R3 rx-ready cleared", rdata, 8'h02);
        // transmit
        wr(0, 8'hF7);
        chk("R5 tx_code", tx_code, 7);
        rd(1);
        chk("R5 tx-empty cleared", rdata, 8'h00);
        drv(0, 0, 0, 0, 0, 0, 1); idle();
        chk("R8 burst irq", irq_n, 0);
        rd(1);
        chk("R5 tx-empty set", rdata, 8'h03);
        // deselected cycles
        drv(0, 0, 0, 8'h09, 0, 0, 0); drv(0, 1, 1, 0, 0, 0, 0); idle();
        chk("R11 tx_code", tx_code, 7);
        chk("R11 rdata", rdata, 8'h03);
        // burst off: tx_ready must not interrupt
        wr(1, 8'h0C); wr(1, 8'h00);
        drv(0, 0, 0, 0, 0, 0, 1); idle();
        chk("R8 no irq without burst", irq_oe, 0);
        // IE off: digit must not interrupt
        wr(1, 8'h00);
        drv(0, 0, 0, 0, 1, 3, 0); idle();
        chk("R9 no irq", irq_oe, 0);
        // simultaneous clear and set
        wr(1, 8'h04);
        drv(1, 1, 1, 0, 1, 5, 0); idle();
        chk("R10 irq survives", irq_oe, 1);
        drv(1, 1, 0, 0, 1, 6, 0); idle();
        chk("R10 old code read", rdata, 8'h05);
        rd(1);
        chk("R10 rx-ready kept", (rdata >> 2) & 1, 1);
        // all codes
        for (int k = 0; k < 16; k++) begin
            drv(0, 0, 0, 0, 1, k, 0); idle();
            rd(0);
            chk("R2/R3 code sweep", rdata, k);
        end
        repeat (3) idle();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #50000;
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule